// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block recovers bytes from an asynchronous serial line. It watches the line on a strobe that arrives at sixteen times the bit rate. A separate block generates that strobe, and the strobe may be any rate slower than the system clock. Each frame is a low start bit, eight data bits with the least significant bit first, and a stop bit. The line first passes through a two-flop synchroniser. The receiver then looks for a high-to-low transition at a strobe.

The strobe that sees the transition becomes phase 0 of the start bit, and a phase counter restarts from there. Every bit time is sixteen phases long. Three samples are taken in the middle of each bit, and the bit takes the value that at least two of them show. If the start bit resolves high, the frame is dropped and the search for an edge begins again.

When the stop bit resolves, the byte and the stop bit value are loaded into output registers and a done flag is raised. The receiver then goes back to searching for an edge. A receive-enable input gates the whole function. A clear strobe lowers the done flag.

Top module: `oversample_rx`

## Requirements
- R1: After reset `rx_done` is 0, `rx_byte` is 0x00 and `rx_stop` is 0.
- R2: While `rx_en` is 1 and no frame is in progress, a frame starts at the first `os_tick` where the synchronised line is 0 and was 1 at the previous `os_tick`. That tick is phase 0 of the start bit.
- R3: A bit's value is the majority of the synchronised line at phases 7, 8 and 9 of its bit time. A single disturbed sample does not change the bit, and two disturbed samples do.
- R4: If the start bit resolves to 1, the frame is dropped: no flag and no output change. Edge search resumes.
- R5: The eight data bits fill `rx_byte` least significant bit first: the first data bit lands in bit 0.
- R6: When the stop bit resolves, `rx_byte` and `rx_stop` are loaded and `rx_done` rises. This holds even when the stop bit value is 0. `rx_byte` never changes at any other time.
- R7: `rx_done` stays 1 until `flag_clr` is 1 on a clock edge. If a frame completes on the same edge as a clear, the flag is set.
- R8: With `rx_en` at 0 no frame is started. Dropping `rx_en` during a frame abandons it on the next edge, and no flag is raised.
- R9: Phase 9 of the stop bit ends the frame. A start edge arriving right after the stop bit begins the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Asynchronous serial line |
| flag_clr | input | 1 | Clears the done flag |
| rx_byte | output | 8 | Last received byte |
| rx_stop | output | 1 | Stop bit value of the last frame |
| rx_done | output | 1 | Frame-received flag |

## Verification
A phase counter that is off by one moves the three-sample window. The bench therefore corrupts two adjacent samples in a data bit and expects exactly that bit to flip in `rx_byte`, which shows any wrong window as soon as that frame completes. A bit counter or shift register that is off shows a shifted or wrong byte when the stop bit resolves, so roughly 150 oversample ticks after the edge. A broken abort path shows as an unexpected `rx_done` pulse. A reference model compares all three outputs on every clock, so a flag that is set or cleared in the wrong cycle is seen within one cycle.

// File: rtl/oversample_rx_pkg.sv
package oversample_rx_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_vote.sv
// Holds the first two mid-bit samples; the third arrives live and the
// two-of-three result is valid on the tick at phase MID+1.
module rx_vote #(
    parameter int OSR = 16,
    parameter int MID = 8,
    localparam int CW = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [CW-1:0] phase,
    input  logic          din,
    output logic          maj
);
    logic first_d, first_q, second_d, second_q;

    always_comb begin
        first_d  = first_q;
        second_d = second_q;
        if (smp_en && phase == CW'(MID - 1)) first_d  = din;
        if (smp_en && phase == CW'(MID))     second_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q  <= 1'b1;
            second_q <= 1'b1;
        end else begin
            first_q  <= first_d;
            second_q <= second_d;
        end
    end

    assign maj = (first_q & second_q) | (first_q & din) | (second_q & din);
endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
    import oversample_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int MID    = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic              rxd,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_stop,
    output logic              rx_done
);
    localparam int CW       = $clog2(OSR);
    localparam int SW       = DATA_W + 1;
    localparam int LAST_BIT = DATA_W + 1;
    localparam int BCW      = $clog2(LAST_BIT + 1);
    localparam int VOTE_PH  = MID + 1;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     ph;
        logic [BCW-1:0]    bidx;
        logic [SW-1:0]     sh;
        logic              prev;
        logic [DATA_W-1:0] data;
        logic              stop;
        logic              done;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     line_s;
    logic     bit_maj;

    rx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (line_s)
    );

    rx_vote #(.OSR(OSR), .MID(MID)) u_vote (
        .clk   (clk),
        .rst_n (rst_n),
        .smp_en(os_tick && r_q.st == ST_BUSY),
        .phase (r_q.ph),
        .din   (line_s),
        .maj   (bit_maj)
    );

    always_comb begin
        r_d = r_q;
        if (os_tick)  r_d.prev = line_s;
        if (flag_clr) r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (os_tick && rx_en && r_q.prev && !line_s) begin
                    r_d.st   = ST_BUSY;
                    r_d.ph   = CW'(1);
                    r_d.bidx = '0;
                    r_d.sh   = '1;
                end
            end
            ST_BUSY: begin
                if (!rx_en) begin
                    r_d.st = ST_IDLE;
                end else if (os_tick) begin
                    r_d.ph = (r_q.ph == CW'(OSR - 1)) ? '0 : r_q.ph + 1'b1;
                    if (r_q.ph == CW'(VOTE_PH)) begin
                        if (r_q.bidx == '0 && bit_maj) begin
                            r_d.st = ST_IDLE;
                        end else if (r_q.bidx == BCW'(LAST_BIT)) begin
                            r_d.data = r_q.sh[SW-1:1];
                            r_d.stop = bit_maj;
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else begin
                            r_d.sh   = {bit_maj, r_q.sh[SW-1:1]};
                            r_d.bidx = r_q.bidx + 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.sh   <= '1;
            r_q.prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_byte = r_q.data;
    assign rx_stop = r_q.stop;
    assign rx_done = r_q.done;

    // R8: losing the enable always leaves the receiver idle on the next edge
    p_en_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> r_q.st == ST_IDLE);

    // R7: a clear while idle always drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && r_q.st == ST_IDLE) |=> !rx_done);

    // R6: the output byte only moves together with a raised flag
    p_byte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_done);

    // R9: completion always returns to edge search
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> r_q.st == ST_IDLE);

    // R4: a completed frame always had a low start bit in the register
    p_start_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> !$past(r_q.sh[0]));

    // R3: bit index never passes the stop bit
    p_bidx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_BUSY |-> r_q.bidx <= BCW'(LAST_BIT));
endmodule

// File: tb/oversample_rx_tb.sv
module oversample_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_stop;
    logic       rx_done;

    int n_tests = 0;
    int n_fail  = 0;

    oversample_rx u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .rxd(rxd), .flag_clr(flag_clr), .rx_byte(rx_byte),
        .rx_stop(rx_stop), .rx_done(rx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tdiv = 0;
    always @(negedge clk) begin
        tdiv    = (tdiv + 1) % TICK_DIV;
        os_tick = (tdiv == 0);
    end

    // behavioural reference model
    logic       m_s1 = 1, m_s2 = 1, m_prev = 1;
    logic       m_done = 0, m_stop = 0;
    logic [7:0] m_byte = 0, m_acc = 0;
    bit         m_busy = 0;
    int         m_phase = 0, m_bit = 0, m_ones = 0;

    always @(posedge clk) begin
        logic line;
        line = m_s2;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_done = 0; m_stop = 0;
            m_byte = 0; m_busy = 0;
        end else begin
            if (flag_clr) m_done = 0;
            if (m_busy && !rx_en) begin
                m_busy = 0;
            end else if (os_tick) begin
                if (!m_busy) begin
                    if (rx_en && m_prev && !line) begin
                        m_busy = 1; m_phase = 1; m_bit = 0;
                    end
                end else begin
                    if (m_phase == 7) m_ones = 0;
                    if (m_phase >= 7 && m_phase <= 9) m_ones += int'(line);
                    if (m_phase == 9) begin
                        if (m_bit == 0 && m_ones >= 2) m_busy = 0;
                        else if (m_bit == 9) begin
                            m_byte = m_acc; m_stop = (m_ones >= 2);
                            m_done = 1; m_busy = 0;
                        end else begin
                            if (m_bit >= 1) m_acc[m_bit-1] = (m_ones >= 2);
                            m_bit++;
                        end
                    end
                    m_phase = (m_phase + 1) % 16;
                end
                m_prev = line;
            end
            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (rx_done !== m_done || rx_byte !== m_byte || rx_stop !== m_stop) begin
                n_fail++;
                $display("FAIL R2/R3 model: act done=%0b byte=%02h stop=%0b exp done=%0b byte=%02h stop=%0b",
                         rx_done, rx_byte, rx_stop, m_done, m_byte, m_stop);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // hold rxd at v for n oversample ticks, changing right after a tick
    task automatic tk(input logic v, input int n);
        rxd = v;
        repeat (n) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stp, input int gbit,
                        input logic [15:0] gmask, input int trail);
        tk(1'b1, 2);
        tk(1'b0, 16);
        for (int i = 0; i < 8; i++)
            for (int t = 0; t < 16; t++)
                tk((i == gbit && gmask[t]) ? ~b[i] : b[i], 1);
        tk(stp, 16);
        tk(1'b1, trail);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit saw;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", rx_done, 0);
        chk("R1 byte", rx_byte, 8'h00);
        chk("R1 stop", rx_stop, 0);

        rx_en = 1'b1;
        send(8'hA5, 1'b1, -1, 16'h0, 4);
        chk("R5 byte A5", rx_byte, 8'hA5);
        chk("R6 stop 1", rx_stop, 1);
        chk("R2 done", rx_done, 1);
        repeat (5) @(negedge clk);
        chk("R7 held", rx_done, 1);
        clear_flag();
        chk("R7 cleared", rx_done, 0);

        send(8'h01, 1'b1, -1, 16'h0, 4);
        chk("R5 lsb first", rx_byte, 8'h01);
        clear_flag();

        send(8'h3C, 1'b0, -1, 16'h0, 4);
        chk("R6 byte stop0", rx_byte, 8'h3C);
        chk("R6 stop 0", rx_stop, 0);
        chk("R6 done stop0", rx_done, 1);
        clear_flag();

        // one corrupted sample at phase 8 in bit 2
        send(8'h00, 1'b1, 2, 16'h0100, 4);
        chk("R3 single glitch", rx_byte, 8'h00);
        clear_flag();
        // phases 7 and 8 corrupted in bit 5
        send(8'hFF, 1'b1, 5, 16'h0180, 4);
        chk("R3 double glitch", rx_byte, 8'hDF);
        clear_flag();
        // phases 8 and 9 corrupted in bit 0
        send(8'h00, 1'b1, 0, 16'h0300, 4);
        chk("R3 late pair", rx_byte, 8'h01);
        clear_flag();

        // false start: low for five ticks only
        tk(1'b1, 2); tk(1'b0, 5); tk(1'b1, 200);
        chk("R4 false start flag", rx_done, 0);
        chk("R4 false start byte", rx_byte, 8'h01);

        // disabled receiver ignores a full frame
        rx_en = 1'b0;
        send(8'h77, 1'b1, -1, 16'h0, 4);
        chk("R8 disabled flag", rx_done, 0);
        chk("R8 disabled byte", rx_byte, 8'h01);

        // drop the enable mid-frame
        rx_en = 1'b1;
        tk(1'b1, 2); tk(1'b0, 16); tk(1'b1, 20);
        rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
        tk(1'b1, 200);
        chk("R8 mid abort flag", rx_done, 0);
        chk("R8 mid abort byte", rx_byte, 8'h01);

        // back-to-back frames with no idle gap
        send(8'h5A, 1'b1, -1, 16'h0, 0);
        chk("R9 first", rx_byte, 8'h5A);
        clear_flag();
        send(8'hC3, 1'b1, -1, 16'h0, 4);
        chk("R9 second", rx_byte, 8'hC3);
        chk("R9 flag", rx_done, 1);

        // clear held high through a frame: set wins in the completion cycle
        clear_flag();
        saw = 0;
        flag_clr = 1'b1;
        fork
            send(8'h96, 1'b1, -1, 16'h0, 4);
            begin
                repeat (700) begin
                    @(negedge clk);
                    if (rx_done) saw = 1;
                end
            end
        join
        flag_clr = 1'b0;
        @(negedge clk);
        chk("R7 set beats clear", int'(saw), 1);
        chk("R7 cleared after", rx_done, 0);
        chk("R7 byte", rx_byte, 8'h96);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule